// File: doc/BRIEF.md
# Shift-Add Sequential Multiplier

This block multiplies two unsigned operands of `W` bits (4 by default) and returns a product of `2W` bits. It does so over several clock cycles, using one `W`-bit adder. The operands are captured when a one-cycle `start` request is accepted. The block then runs `W` iterations, and each iteration has two steps.

- **Add step.** The low bit of the multiplier register selects either the multiplicand or zero. That value is added to the upper half of the product register, and the sum is written back into that upper half.
- **Shift step.** The whole product register moves right by one bit. The carry produced by the preceding add enters the top bit. The multiplier register also moves right at the same time, with zero entering its top bit.

After the last shift, `done` pulses for one cycle. The product stays on `product` until the next accepted `start`.

The design has two parts under a thin top. A datapath holds the registers, the addend selector and a ripple adder. A small controller steps through the iterations and drives the datapath through a struct of strobes. The clear input is asynchronous and returns everything to idle.

Top module: `shiftAddMultiplier`

## Requirements
- R1: While `clr` is high, `product` reads 0 and `done` reads 0 immediately, without waiting for a clock edge. After release, the block stays idle until `start` is sampled high.
- R2: Let `start` be sampled high in idle at rising edge k. Then `done` is high only between edges k+2W and k+2W+1, which is 2W+1 negative-edge samples after `start` was raised, and is low again on the next cycle.
- R3: While `done` is high, `product` equals the unsigned product of the two operands. For example, 4'b1011 times 4'b1101 gives 8'b10001111.
- R4: The operands are sampled only at the edge that accepts `start`. Any later change on `mcandIn` or `mplierIn` does not alter the result.
- R5: A `start` that is high while an operation is in progress, or during the `done` cycle, is ignored. The timing and the result of the running operation are unchanged.
- R6: Each iteration is one add step followed by one shift step. The add step writes `upper + (multiplier LSB ? multiplicand : 0)` into the upper half and leaves the lower half unchanged.
- R7: The shift step moves the whole product right by one bit. The carry out of the immediately preceding add step enters bit 2W-1, so sums that overflow W bits still give the exact product, for example 15 times 15 gives 225.
- R8: Between `done` and the next accepted `start`, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| start | input | 1 | Request to begin; accepted only when idle |
| mcandIn | input | W | Multiplicand operand |
| mplierIn | input | W | Multiplier operand |
| product | output | 2W | Product register contents |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The hardest condition to create is an add step whose sum overflows W bits when the upper half of the product is already non-zero. Only then does the stored carry decide the top bit at the following shift. Exhaustive runs over every operand pair reach this condition, including all-ones operands. Seeded random runs additionally scramble the operands and hold `start` high throughout the operation. One run asserts clear partway through, which proves the sequence aborts and then restarts cleanly.

// File: rtl/shiftAddPkg.sv
package shiftAddPkg;

  // Strobes from the controller to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;      // capture operands, zero the product
    logic loadProd;  // write adder sum into the upper half
    logic shift;     // shift product and multiplier right
  } mulStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FIN   = 2'd3
  } mulState_t;

endpackage

// File: rtl/rippleAdder.sv
module rippleAdder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic carry;

  always_comb begin
    carry = 1'b0;
    sum   = '0;
    for (int i = 0; i < W; i++) begin
      sum[i] = a[i] ^ b[i] ^ carry;
      carry  = (a[i] & b[i]) | (carry & (a[i] ^ b[i]));
    end
    cout = carry;
  end

endmodule

// File: rtl/shiftAddDatapath.sv
module shiftAddDatapath
  import shiftAddPkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  mulStrobes_t   strobes,
  input  logic [W-1:0]  mcandIn,
  input  logic [W-1:0]  mplierIn,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [W-1:0]  mcandQ;
  logic [W-1:0]  mplierQ;
  logic [PW-1:0] prodQ;
  logic          carryQ;   // carry of the sum most recently stored

  logic [W-1:0]  addend;
  logic [W-1:0]  sum;
  logic          sumCarry;

  // Multiplier LSB gates the multiplicand onto the adder.
  assign addend = mplierQ[0] ? mcandQ : '0;

  rippleAdder #(.W(W)) u_adder (
    .a    (prodQ[PW-1:W]),
    .b    (addend),
    .sum  (sum),
    .cout (sumCarry)
  );

  // Multiplicand register.
  always_ff @(posedge clk or posedge clr) begin
    if (clr)               mcandQ <= '0;
    else if (strobes.load) mcandQ <= mcandIn;
  end

  // Multiplier register: load wins over shift.
  always_ff @(posedge clk or posedge clr) begin
    if (clr)                mplierQ <= '0;
    else if (strobes.load)  mplierQ <= mplierIn;
    else if (strobes.shift) mplierQ <= {1'b0, mplierQ[W-1:1]};
  end

  // Product register and the carry captured with each stored sum.
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      prodQ  <= '0;
      carryQ <= 1'b0;
    end else if (strobes.load) begin
      prodQ  <= '0;
      carryQ <= 1'b0;
    end else if (strobes.loadProd) begin
      prodQ[PW-1:W] <= sum;
      carryQ        <= sumCarry;
    end else if (strobes.shift) begin
      prodQ <= {carryQ, prodQ[PW-1:1]};
    end
  end

  assign product = prodQ;

endmodule

// File: rtl/shiftAddControl.sv
module shiftAddControl
  import shiftAddPkg::*;
#(
  parameter int W = 4
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  mulState_t     stateQ;
  mulState_t     stateD;
  logic [CW-1:0] iterQ;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      stateQ <= ST_IDLE;
      iterQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE)       iterQ <= '0;
      else if (stateQ == ST_SHIFT) iterQ <= iterQ + 1'b1;
    end
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    done    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateD       = ST_ADD;
        end
      end
      ST_ADD: begin
        strobes.loadProd = 1'b1;
        stateD           = ST_SHIFT;
      end
      ST_SHIFT: begin
        strobes.shift = 1'b1;
        stateD        = (iterQ == LAST_ITER) ? ST_FIN : ST_ADD;
      end
      ST_FIN: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/shiftAddMultiplier.sv
module shiftAddMultiplier
  import shiftAddPkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           start,
  input  logic [W-1:0]   mcandIn,
  input  logic [W-1:0]   mplierIn,
  output logic [2*W-1:0] product,
  output logic           done
);

  mulStrobes_t strobes;

  shiftAddControl #(.W(W)) u_control (
    .clk     (clk),
    .clr     (clr),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  shiftAddDatapath #(.W(W)) u_datapath (
    .clk      (clk),
    .clr      (clr),
    .strobes  (strobes),
    .mcandIn  (mcandIn),
    .mplierIn (mplierIn),
    .product  (product)
  );

endmodule

// File: rtl/shiftAddMultiplierChecker.sv
module shiftAddMultiplierChecker
  import shiftAddPkg::*;
#(
  parameter int W = 4
) (
  input logic           clk,
  input logic           clr,
  input logic           done,
  input logic [2*W-1:0] product,
  input mulStrobes_t    strobes
);

  localparam int PW = 2 * W;

  logic anyStrobe;
  assign anyStrobe = strobes.load | strobes.loadProd | strobes.shift;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (clr)
    done |=> !done) else $error("done wider than one cycle"); // R2

  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (clr)
    done |-> $past(strobes.shift)) else $error("done not preceded by shift"); // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (clr)
    $onehot0({strobes.load, strobes.loadProd, strobes.shift})) else $error("strobes overlap"); // R6

  AST_SHIFT_AFTER_ADD: assert property (@(posedge clk) disable iff (clr)
    strobes.shift |-> $past(strobes.loadProd)) else $error("shift without add"); // R6

  AST_ADD_KEEPS_LOW: assert property (@(posedge clk) disable iff (clr)
    $past(strobes.loadProd) |-> product[W-1:0] == $past(product[W-1:0])) else $error("add touched low half"); // R6

  AST_SHIFT_MOVES_RIGHT: assert property (@(posedge clk) disable iff (clr)
    $past(strobes.shift) |-> product[PW-2:0] == $past(product[PW-1:1])) else $error("shift mismatch"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (clr)
    !$past(anyStrobe) |-> $stable(product)) else $error("product moved without strobe"); // R8

endmodule

bind shiftAddMultiplier shiftAddMultiplierChecker #(.W(W)) u_checker (
  .clk     (clk),
  .clr     (clr),
  .done    (done),
  .product (product),
  .strobes (strobes)
);

// File: tb/test_shiftAddMultiplier.sv
`timescale 1ns/1ps
module test_shiftAddMultiplier;

  localparam int W  = 4;
  localparam int PW = 2 * W;
  localparam int LATENCY = 2 * W + 1;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcandIn = '0;
  logic [W-1:0]  mplierIn = '0;
  logic [PW-1:0] product;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  shiftAddMultiplier #(.W(W)) i_shiftAddMultiplier (
    .clk      (clk),
    .clr      (clr),
    .start    (start),
    .mcandIn  (mcandIn),
    .mplierIn (mplierIn),
    .product  (product),
    .done     (done)
  );

  function automatic logic [PW-1:0] expMul(logic [W-1:0] a, logic [W-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic check(bit ok, string req, longint actual, longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One multiplication; optionally scramble operands and hold start high.
  task automatic runMul(logic [W-1:0] a, logic [W-1:0] b, bit scramble, bit holdStart);
    int lat = 0;
    bit seen = 0;
    logic [PW-1:0] exp;
    exp = expMul(a, b);
    @(negedge clk);
    mcandIn  = a;
    mplierIn = b;
    start    = 1'b1;
    while (!seen && lat < 40) begin
      @(negedge clk);
      lat++;
      if (scramble) begin
        mcandIn  = W'($urandom);
        mplierIn = W'($urandom);
      end
      if (!holdStart) start = 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    check(lat == LATENCY, "R2 latency", lat, LATENCY);
    check(product == exp, "R3 R6 R7 product (R4 R5 when scrambled/held)", product, exp);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    #1;
    check(product == '0, "R1 product in clear", product, 0);
    check(done == 1'b0, "R1 done in clear", done, 0);
    repeat (3) @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 idle after release", product, 0);

    // Directed corners
    runMul(4'b1011, 4'b1101, 0, 0);   // R3 example 143
    runMul(4'hF, 4'hF, 0, 0);         // R7 carry path 225
    runMul(4'h0, 4'hF, 0, 0);
    runMul(4'hF, 4'h1, 0, 0);

    // R8: product holds while idle
    begin
      logic [PW-1:0] held;
      held = product;
      repeat (6) @(negedge clk);
      check(product == held, "R8 hold after done", product, held);
    end

    // Exhaustive operand pairs
    for (int i = 0; i < (1 << PW); i++) begin
      runMul(W'(i >> W), W'(i), 0, 0);
    end

    // Random runs with scrambled operands (R4) and held start (R5)
    for (int r = 0; r < 60; r++) begin
      runMul(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1: clear in the middle of an operation
    @(negedge clk);
    mcandIn = 4'hD; mplierIn = 4'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    #1;
    check(product == '0, "R1 async clear product", product, 0);
    check(done == 1'b0, "R1 async clear done", done, 0);
    @(negedge clk);
    clr = 1'b0;
    begin
      bit sawDone = 0;
      repeat (2 * LATENCY) begin
        @(negedge clk);
        if (done) sawDone = 1;
      end
      check(!sawDone, "R1 no done after aborted run", sawDone, 0);
    end
    runMul(4'hD, 4'h7, 0, 0);

    finishRun();
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

endmodule